// File: doc/BRIEF.md
# Stack Frame Sequencer

This block moves processor register state between a register set and a byte-wide synchronous memory through a 16-bit stack pointer. It serves the stack instructions and the trap instructions of an 8-bit processor core. The core presents a command, an 8-bit register-select mask, the current register values and the stack pointer, then pulses start. The sequencer makes one memory access per clock and returns the updated registers, the new stack pointer and, for traps, a program counter taken from a vector. It signals completion with a one-cycle done pulse.

Registers are kept as a 12-byte frame whose byte order matches their order in stack memory. Lowest address first, the order is: flags, A, B, direct-page, X high, X low, Y high, Y low, U high, U low, PC high, PC low. A push walks this frame from the top down and pre-decrements the pointer. A pull walks it from the bottom up and post-increments the pointer. Trap commands push the whole frame and then fetch a vector. The return command reads the flags byte first and uses its entire-state bit to decide how much more to pull.

Top module: `stack_seq`

## Requirements
- R1: After reset, and whenever idle, `busy_o` and `done_o` are low and no memory access is made (`mem_we_o` and `mem_re_o` are low).
- R2: Push (cmd 0) selects registers by mask bit: bit 0 flags, bit 1 A, bit 2 B, bit 3 direct-page, bit 4 X, bit 5 Y, bit 6 U, bit 7 PC. Bits are handled from 7 down to 0. Before each byte write the pointer drops by one. A 16-bit register writes its low byte first, so the low byte sits at the higher address. Pushing A alone from 0x8000 leaves 0x7FFF, and mask 0x16 leaves 0x7FFC.
- R3: Pull (cmd 1) uses the same mask bits, handled from bit 0 up to bit 7. Each byte is read at the pointer, which then rises by one. A 16-bit register takes its high byte first. Registers outside the mask keep their input values.
- R4: At most one memory access is made per clock. `done_o` is high for exactly one cycle. For a push of n bytes it comes n cycles after start is taken; for a pull it comes n+1 cycles after. An empty mask gives done in the first cycle with no access.
- R5: Software trap (cmd 2) sets flag bit 7 (entire) before pushing all 12 bytes. It then sets flag bits 4 and 6 (interrupt masks) and loads PC from 0xFFFA (high byte) and 0xFFFB (low byte).
- R6: Alternate software trap (cmd 3) pushes all 12 bytes with the flags unchanged, vectors through 0xFFF4/0xFFF5 and leaves all flags unchanged.
- R7: Reset trap (cmd 4) pushes all 12 bytes without setting flag bit 7, vectors through 0xFFFE/0xFFFF and leaves flag bits 4 and 6 unchanged.
- R8: Fast trap (cmd 5) pushes all 12 bytes, vectors through 0xFFF6/0xFFF7 and changes no flag.
- R9: Return (cmd 6) reads the flags byte at the pointer and spends one cycle deciding. If flag bit 7 is set it then pulls A, B, direct-page, X, Y, U and PC (11 bytes). If it is clear it pulls only PC, high byte then low byte.
- R10: A start pulse that arrives while busy is ignored. The running command's access sequence and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| cmd_i | input | 3 | Command code |
| mask_i | input | 8 | Register-select mask for push and pull |
| cc_i | input | 8 | Flags in |
| a_i | input | 8 | Accumulator A in |
| b_i | input | 8 | Accumulator B in |
| dp_i | input | 8 | Direct-page register in |
| x_i | input | 16 | Index X in |
| y_i | input | 16 | Index Y in |
| u_i | input | 16 | Other stack pointer in |
| pc_i | input | 16 | Program counter in |
| sp_i | input | 16 | Stack pointer in |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe; data returns next cycle |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after `mem_re_o` |
| cc_o | output | 8 | Flags out |
| a_o | output | 8 | A out |
| b_o | output | 8 | B out |
| dp_o | output | 8 | Direct-page out |
| x_o | output | 16 | X out |
| y_o | output | 16 | Y out |
| u_o | output | 16 | U out |
| pc_o | output | 16 | PC out |
| sp_o | output | 16 | Stack pointer out |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Counting from the first cycle after start is taken, a push issues one write per cycle and raises done in cycle n. A pull issues reads in cycles 0 to n-1, spends cycle n on the final data capture and raises done in cycle n+1. A trap writes in cycles 0 to 11, reads the vector in cycles 12 and 13, and raises done in cycle 15. A return reads the flags in cycle 0, decides in cycle 1, then pulls 11 or 2 bytes and raises done two cycles after its last read. The reference model turns each command into a per-cycle list of expected access, address, data and done values. The bench compares every listed cycle at the falling edge, reads the register outputs in the done cycle, and expects idle one cycle later.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int MASK_W = 8;
  localparam int NSLOT  = 12;
  localparam int SLOT_W = $clog2(NSLOT);

  localparam logic [BYTE_W-1:0] CC_E = 8'h80;
  localparam logic [BYTE_W-1:0] CC_F = 8'h40;
  localparam logic [BYTE_W-1:0] CC_I = 8'h10;

  localparam logic [NSLOT-1:0] FULL_SLOTS = '1;
  localparam logic [NSLOT-1:0] PC_SLOTS   = NSLOT'(12'hC00);
  localparam logic [NSLOT-1:0] RTI_REST   = NSLOT'(12'hFFE);

  localparam logic [SLOT_W-1:0] SL_CC  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SL_PCH = SLOT_W'(10);
  localparam logic [SLOT_W-1:0] SL_PCL = SLOT_W'(11);

  typedef enum logic [2:0] {
    CMD_PUSH, CMD_PULL, CMD_SWI, CMD_SWI_ALT,
    CMD_RST_TRAP, CMD_FAST_TRAP, CMD_RTI, CMD_NONE
  } cmd_e;

  // mask bit -> frame byte slots (lowest stack address = slot 0)
  function automatic logic [NSLOT-1:0] slot_mask(logic [MASK_W-1:0] m);
    logic [NSLOT-1:0] s;
    s[3:0]   = m[3:0];
    s[5:4]   = {2{m[4]}};
    s[7:6]   = {2{m[5]}};
    s[9:8]   = {2{m[6]}};
    s[11:10] = {2{m[7]}};
    return s;
  endfunction
endpackage

// File: rtl/stk_pick.sv
module stk_pick #(
  parameter int W = 12,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  input  logic          hi_first_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |req_i;
    if (hi_first_i) begin
      for (int i = 0; i < W; i++) if (req_i[i]) idx_o = IW'(i);
    end else begin
      for (int i = W - 1; i >= 0; i--) if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/stk_vec_sel.sv
module stk_vec_sel
  import stk_pkg::*;
(
  input  logic [2:0]        cmd_i,
  output logic [ADDR_W-1:0] vec_o,
  output logic              trap_o,
  output logic              set_e_o,
  output logic              set_if_o
);
  always_comb begin
    vec_o    = '0;
    trap_o   = 1'b1;
    set_e_o  = 1'b0;
    set_if_o = 1'b0;
    unique case (cmd_e'(cmd_i))
      CMD_SWI: begin
        vec_o    = ADDR_W'(16'hFFFA);
        set_e_o  = 1'b1;
        set_if_o = 1'b1;
      end
      CMD_SWI_ALT:   vec_o = ADDR_W'(16'hFFF4);
      CMD_RST_TRAP:  vec_o = ADDR_W'(16'hFFFE);
      CMD_FAST_TRAP: vec_o = ADDR_W'(16'hFFF6);
      default:       trap_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        cmd_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [BYTE_W-1:0] cc_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic [BYTE_W-1:0] dp_i,
  input  logic [ADDR_W-1:0] x_i,
  input  logic [ADDR_W-1:0] y_i,
  input  logic [ADDR_W-1:0] u_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] cc_o,
  output logic [BYTE_W-1:0] a_o,
  output logic [BYTE_W-1:0] b_o,
  output logic [BYTE_W-1:0] dp_o,
  output logic [ADDR_W-1:0] x_o,
  output logic [ADDR_W-1:0] y_o,
  output logic [ADDR_W-1:0] u_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              busy_o,
  output logic              done_o
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH, ST_PULL, ST_RTI_CC, ST_RTI_DEC,
    ST_VEC_HI, ST_VEC_LO, ST_DRAIN, ST_FIN
  } state_e;

  state_e              state_q;
  logic [BYTE_W-1:0]   frame_q [NSLOT];
  logic [ADDR_W-1:0]   sp_q, vec_q;
  logic [NSLOT-1:0]    rem_q, rem_clr, start_slots;
  logic                pend_v_q, trap_q, set_if_q;
  logic [SLOT_W-1:0]   pend_idx_q, pick_idx;
  logic                pick_any;
  logic [ADDR_W-1:0]   vs_vec;
  logic                vs_trap, vs_set_e, vs_set_if;

  stk_pick #(.W(NSLOT)) i_pick (
    .req_i      (rem_q),
    .hi_first_i (state_q == ST_PUSH),
    .idx_o      (pick_idx),
    .any_o      (pick_any)
  );

  stk_vec_sel i_vec_sel (
    .cmd_i    (cmd_i),
    .vec_o    (vs_vec),
    .trap_o   (vs_trap),
    .set_e_o  (vs_set_e),
    .set_if_o (vs_set_if)
  );

  assign rem_clr     = rem_q & ~(NSLOT'(1) << pick_idx);
  assign start_slots = slot_mask(mask_i);

  always_comb begin
    mem_we_o    = (state_q == ST_PUSH) && pick_any;
    mem_re_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_PUSH: begin
        mem_addr_o  = sp_q - ADDR_W'(1);
        mem_wdata_o = frame_q[pick_idx];
      end
      ST_PULL, ST_RTI_CC: begin
        mem_re_o   = 1'b1;
        mem_addr_o = sp_q;
      end
      ST_VEC_HI: begin
        mem_re_o   = 1'b1;
        mem_addr_o = vec_q;
      end
      ST_VEC_LO: begin
        mem_re_o   = 1'b1;
        mem_addr_o = vec_q + ADDR_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      for (int i = 0; i < NSLOT; i++) frame_q[i] <= '0;
      sp_q       <= '0;
      vec_q      <= '0;
      rem_q      <= '0;
      pend_v_q   <= 1'b0;
      pend_idx_q <= '0;
      trap_q     <= 1'b0;
      set_if_q   <= 1'b0;
    end else begin
      // read data lands one cycle after the access
      if (pend_v_q) frame_q[pend_idx_q] <= mem_rdata_i;
      pend_v_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          frame_q[0]  <= cc_i | (vs_set_e ? CC_E : '0);
          frame_q[1]  <= a_i;
          frame_q[2]  <= b_i;
          frame_q[3]  <= dp_i;
          frame_q[4]  <= x_i[15:8];
          frame_q[5]  <= x_i[7:0];
          frame_q[6]  <= y_i[15:8];
          frame_q[7]  <= y_i[7:0];
          frame_q[8]  <= u_i[15:8];
          frame_q[9]  <= u_i[7:0];
          frame_q[10] <= pc_i[15:8];
          frame_q[11] <= pc_i[7:0];
          sp_q        <= sp_i;
          vec_q       <= vs_vec;
          trap_q      <= vs_trap;
          set_if_q    <= vs_set_if;
          if (vs_trap) begin
            rem_q   <= FULL_SLOTS;
            state_q <= ST_PUSH;
          end else begin
            rem_q <= start_slots;
            unique case (cmd_e'(cmd_i))
              CMD_PUSH: state_q <= (|start_slots) ? ST_PUSH : ST_FIN;
              CMD_PULL: state_q <= (|start_slots) ? ST_PULL : ST_FIN;
              CMD_RTI:  state_q <= ST_RTI_CC;
              default:  state_q <= ST_FIN;
            endcase
          end
        end
        ST_PUSH: begin
          sp_q  <= sp_q - ADDR_W'(1);
          rem_q <= rem_clr;
          if (rem_clr == '0) begin
            if (trap_q) begin
              state_q <= ST_VEC_HI;
              if (set_if_q) frame_q[0] <= frame_q[0] | CC_I | CC_F;
            end else begin
              state_q <= ST_FIN;
            end
          end
        end
        ST_PULL: begin
          sp_q       <= sp_q + ADDR_W'(1);
          rem_q      <= rem_clr;
          pend_v_q   <= 1'b1;
          pend_idx_q <= pick_idx;
          if (rem_clr == '0) state_q <= ST_DRAIN;
        end
        ST_RTI_CC: begin
          sp_q       <= sp_q + ADDR_W'(1);
          pend_v_q   <= 1'b1;
          pend_idx_q <= SL_CC;
          state_q    <= ST_RTI_DEC;
        end
        ST_RTI_DEC: begin
          rem_q   <= (mem_rdata_i & CC_E) != '0 ? RTI_REST : PC_SLOTS;
          state_q <= ST_PULL;
        end
        ST_VEC_HI: begin
          pend_v_q   <= 1'b1;
          pend_idx_q <= SL_PCH;
          state_q    <= ST_VEC_LO;
        end
        ST_VEC_LO: begin
          pend_v_q   <= 1'b1;
          pend_idx_q <= SL_PCL;
          state_q    <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_FIN;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign cc_o   = frame_q[0];
  assign a_o    = frame_q[1];
  assign b_o    = frame_q[2];
  assign dp_o   = frame_q[3];
  assign x_o    = {frame_q[4], frame_q[5]};
  assign y_o    = {frame_q[6], frame_q[7]};
  assign u_o    = {frame_q[8], frame_q[9]};
  assign pc_o   = {frame_q[10], frame_q[11]};
  assign sp_o   = sp_q;
  assign busy_o = state_q != ST_IDLE;
  assign done_o = state_q == ST_FIN;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] mem_addr_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic [15:0] sp_o,
  input logic        busy_o,
  input logic        done_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_we_o && !mem_re_o && !done_o));

  p_one_access_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_push_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) - 16'd1);

  p_read_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> mem_addr_o == $past(mem_addr_o) + 16'd1);

  p_sp_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(sp_o));
endmodule

bind stack_seq stack_seq_chk i_chk (.*);

// File: tb/test_stack_seq.sv
module test_stack_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic [7:0]  mask_i = '0;
  logic [7:0]  r_cc = '0, r_a = '0, r_b = '0, r_dp = '0;
  logic [15:0] r_x = '0, r_y = '0, r_u = '0, r_pc = '0, r_sp = '0;
  logic [15:0] mem_addr_o, x_o, y_o, u_o, pc_o, sp_o;
  logic        mem_we_o, mem_re_o, busy_o, done_o;
  logic [7:0]  mem_wdata_o, cc_o, a_o, b_o, dp_o;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  mem [int];

  int n_chk = 0, n_fail = 0;
  int q_k[$], q_a[$], q_d[$];
  logic [7:0]  rv [12];
  logic [15:0] e_sp;

  always #5 clk_i = ~clk_i;

  stack_seq i_stack_seq (
    .clk_i, .rst_ni, .start_i, .cmd_i, .mask_i,
    .cc_i(r_cc), .a_i(r_a), .b_i(r_b), .dp_i(r_dp),
    .x_i(r_x), .y_i(r_y), .u_i(r_u), .pc_i(r_pc), .sp_i(r_sp),
    .mem_addr_o, .mem_we_o, .mem_re_o, .mem_wdata_o, .mem_rdata_i(mem_rdata),
    .cc_o, .a_o, .b_o, .dp_o, .x_o, .y_o, .u_o, .pc_o, .sp_o, .busy_o, .done_o
  );

  function automatic logic [7:0] rd(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk_i) begin
    if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
    if (mem_re_o) mem_rdata <= rd(int'(mem_addr_o));
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic qpush(int k, int a, int d);
    q_k.push_back(k); q_a.push_back(a & 16'hFFFF); q_d.push_back(d & 8'hFF);
  endtask

  // model: 16-bit registers sit at mask bits 4..7, high byte at slot 2*b-4
  task automatic m_push(logic [7:0] m);
    for (int b = 7; b >= 0; b--) if (m[b]) begin
      if (b >= 4) begin
        e_sp--; qpush(1, e_sp, rv[2*b-3]);
        e_sp--; qpush(1, e_sp, rv[2*b-4]);
      end else begin
        e_sp--; qpush(1, e_sp, rv[b]);
      end
    end
  endtask

  task automatic m_pull(logic [7:0] m);
    for (int b = 0; b < 8; b++) if (m[b]) begin
      if (b >= 4) begin
        qpush(2, e_sp, 0); rv[2*b-4] = rd(e_sp); e_sp++;
        qpush(2, e_sp, 0); rv[2*b-3] = rd(e_sp); e_sp++;
      end else begin
        qpush(2, e_sp, 0); rv[b] = rd(e_sp); e_sp++;
      end
    end
  endtask

  task automatic run(int cmd, logic [7:0] m, string req, int glitch);
    int k, a, d, vec, i;
    logic [31:0] act, exp;
    q_k.delete(); q_a.delete(); q_d.delete();
    rv[0] = r_cc; rv[1] = r_a; rv[2] = r_b; rv[3] = r_dp;
    rv[4] = r_x[15:8]; rv[5] = r_x[7:0]; rv[6] = r_y[15:8]; rv[7] = r_y[7:0];
    rv[8] = r_u[15:8]; rv[9] = r_u[7:0]; rv[10] = r_pc[15:8]; rv[11] = r_pc[7:0];
    e_sp = r_sp;
    case (cmd)
      0: begin m_push(m); qpush(3, 0, 0); end
      1: begin m_pull(m); if (m != 0) qpush(0, 0, 0); qpush(3, 0, 0); end
      6: begin
        qpush(2, e_sp, 0); rv[0] = rd(e_sp); e_sp++; qpush(0, 0, 0);
        m_pull(rv[0][7] ? 8'hFE : 8'h80);
        qpush(0, 0, 0); qpush(3, 0, 0);
      end
      default: begin
        vec = (cmd == 2) ? 'hFFFA : (cmd == 3) ? 'hFFF4 : (cmd == 4) ? 'hFFFE : 'hFFF6;
        if (cmd == 2) rv[0] = rv[0] | 8'h80;
        m_push(8'hFF);
        if (cmd == 2) rv[0] = rv[0] | 8'h50;
        qpush(2, vec, 0); rv[10] = rd(vec);
        qpush(2, vec + 1, 0); rv[11] = rd(vec + 1);
        qpush(0, 0, 0); qpush(3, 0, 0);
      end
    endcase
    @(negedge clk_i);
    cmd_i = 3'(cmd); mask_i = m; start_i = 1'b1;
    i = 0;
    while (q_k.size() > 0) begin
      @(negedge clk_i);
      start_i = (i == glitch);
      if (i == glitch) begin cmd_i = 3'd1; mask_i = 8'hFF; end
      k = q_k.pop_front(); a = q_a.pop_front(); d = q_d.pop_front();
      act = {4'b0, done_o, busy_o, mem_we_o, mem_re_o,
             (mem_we_o | mem_re_o) ? mem_addr_o : 16'h0, mem_we_o ? mem_wdata_o : 8'h0};
      case (k)
        1: exp = {4'b0, 4'b0110, a[15:0], d[7:0]};
        2: exp = {4'b0, 4'b0101, a[15:0], 8'h0};
        3: exp = {4'b0, 4'b1100, 24'h0};
        default: exp = {4'b0, 4'b0100, 24'h0};
      endcase
      chk($sformatf("R4 %s cycle %0d", req, i), act, exp);
      if (k == 3) begin
        chk({req, " cc"}, 32'(cc_o), 32'(rv[0]));
        chk({req, " a/b/dp"}, {8'h0, a_o, b_o, dp_o}, {8'h0, rv[1], rv[2], rv[3]});
        chk({req, " x/y"}, {x_o, y_o}, {rv[4], rv[5], rv[6], rv[7]});
        chk({req, " u/pc"}, {u_o, pc_o}, {rv[8], rv[9], rv[10], rv[11]});
        chk({req, " sp"}, 32'(sp_o), 32'(e_sp));
      end
      i++;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    chk({req, " R4 done one cycle"}, {30'h0, busy_o, done_o}, 32'h0);
  endtask

  task automatic set_regs(logic [7:0] cc, logic [15:0] sp);
    r_cc = cc; r_a = 8'hA1; r_b = 8'hB2; r_dp = 8'hD3;
    r_x = 16'h1234; r_y = 16'h5678; r_u = 16'h9ABC; r_pc = 16'hDEF0; r_sp = sp;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    mem[32'hFFFA] = 8'h10; mem[32'hFFFB] = 8'h00;
    mem[32'hFFF4] = 8'h20; mem[32'hFFF5] = 8'h00;
    mem[32'hFFFE] = 8'h30; mem[32'hFFFF] = 8'h00;
    mem[32'hFFF6] = 8'h40; mem[32'hFFF7] = 8'h00;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 reset", {28'h0, busy_o, done_o, mem_we_o, mem_re_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle", {28'h0, busy_o, done_o, mem_we_o, mem_re_o}, 32'h0);

    set_regs(8'h00, 16'h8000);
    run(0, 8'h02, "R2 push A", -1);
    run(0, 8'h16, "R2 push A,B,X", -1);
    set_regs(8'h2B, 16'h6000);
    run(0, 8'hFF, "R2 push all", -1);
    run(0, 8'h00, "R4 empty push", -1);
    run(1, 8'h00, "R4 empty pull", -1);

    // R3: pull from known contents, other registers keep inputs
    for (int j = 0; j < 16; j++) mem[32'h5000 + j] = 8'(8'h40 + j);
    set_regs(8'h00, 16'h5000);
    run(1, 8'h16, "R3 pull A,B,X", -1);
    set_regs(8'h00, 16'h5000);
    run(1, 8'h81, "R3 pull cc,pc", -1);
    set_regs(8'h00, 16'h5000);
    run(1, 8'hE8, "R3 pull dp,y,u,pc", -1);

    set_regs(8'h00, 16'h8000);
    run(2, 8'h00, "R5 swi", -1);
    set_regs(8'h05, 16'h8000);
    run(3, 8'h00, "R6 swi alt", -1);
    set_regs(8'h00, 16'h8000);
    run(4, 8'h00, "R7 reset trap", -1);
    set_regs(8'h2A, 16'h8000);
    run(5, 8'h00, "R8 fast trap", -1);

    // R9: full and short return frames
    mem[32'h7000] = 8'h8F;
    for (int j = 1; j < 12; j++) mem[32'h7000 + j] = 8'(8'h60 + j);
    set_regs(8'h00, 16'h7000);
    run(6, 8'h00, "R9 rti full", -1);
    mem[32'h7100] = 8'h01; mem[32'h7101] = 8'h12; mem[32'h7102] = 8'h34;
    set_regs(8'hFF, 16'h7100);
    run(6, 8'h00, "R9 rti short", -1);

    // R10: start while busy is ignored
    set_regs(8'h00, 16'h8000);
    run(0, 8'hF0, "R10 start while busy", 2);
    set_regs(8'h00, 16'h7000);
    run(6, 8'h00, "R10 start during rti", 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule